// File: doc/BRIEF.md
# Max-Min Fair Rate Allocator

This block divides the capacity of one outgoing link among a set of flows so that the result is max-min fair. Software writes one requested rate per flow, the link capacity and the number of flows taking part through a single write port. It then pulses `start`. The engine works through the flows one round at a time. In each round it picks the smallest request that has not yet been served. It computes the current equal share, which is the remaining capacity divided by the number of flows still waiting. The chosen flow receives either its own request or that share, whichever is smaller. The granted amount is then taken from the remaining capacity and the waiting count drops by one.

All rates are unsigned fixed-point numbers with 8 fractional bits, so the value 256 stands for 1.0. The share comes from a restoring divider that produces one quotient bit per cycle. The minimum comes from a scan over all flow slots, one slot per cycle. Every round therefore takes the same number of cycles. When the last flow has been served, `done` rises and stays high. The grant of any flow can then be read at once through the read index port.

Top module: `mmf_alloc`

## Requirements
- R1: A write with `wrAddr` below NUM_FLOWS stores that flow's request. Address NUM_FLOWS stores the link capacity. Address NUM_FLOWS+1 stores the flow count, and a count above NUM_FLOWS is stored as NUM_FLOWS. Only flows with an index below the count take part. All rates are unsigned with 8 fractional bits.
- R2: A `start` pulse seen while the engine is idle or done begins a run. `busy` is high from the cycle after that `start` until the run ends.
- R3: Each round serves the waiting participating flow with the smallest request. When requests are equal, the lowest flow index is served first.
- R4: The fair share of a round is floor(remaining capacity / remaining flow count), in the same fixed-point format.
- R5: A request less than or equal to the fair share is granted in full. A larger request is granted the fair share.
- R6: After each grant, the remaining count falls by exactly one and the remaining capacity falls by exactly the granted amount. No grant exceeds the remaining capacity.
- R7: A run with K participating flows ends exactly K*(NUM_FLOWS+RATE_W+1) rising edges after the edge that sampled `start`. At that point `busy` falls and `done` rises together.
- R8: `done` stays high until the next accepted `start`. `busy` and `done` are never high together.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the completion time nor any grant.
- R10: A start with a flow count of zero raises `done` after the sampling edge, and every grant reads zero.
- R11: `rdGrant` shows the grant of flow `rdIdx` combinationally. Grants are cleared when a run starts, so flows outside the count read zero after it.
- R12: Capacity 256 with requests 26, 128, 2560 and 1280 on flows 0 to 3 gives grants 26, 76, 77 and 77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the configuration port |
| wrAddr | input | $clog2(NUM_FLOWS+2) | Request slot, capacity or flow count select |
| wrData | input | RATE_W | Value to be written |
| start | input | 1 | Starts a run when the engine is idle or done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed; held until the next start |
| rdIdx | input | $clog2(NUM_FLOWS) | Flow whose grant is shown on rdGrant |
| rdGrant | output | RATE_W | Granted rate of flow rdIdx |

## Verification
`busy` is due one edge after the sampling edge of `start`. `done` is due K*(NUM_FLOWS+RATE_W+1) edges after that edge, or one edge after it for a zero count. A behavioural model in the bench advances a countdown on each rising edge. Both flags are compared with that model at every falling edge, so any early or late completion shows up in the exact cycle it happens. Grants are computed by a plain smallest-first loop in the bench. They are read back through `rdIdx` half a cycle after `done` is expected, and the values set out in R12 and R10 are also checked against constants.

// File: rtl/mmf_pkg.sv
`timescale 1ns/1ps
package mmf_pkg;

  // Strobes the sequencer hands to the datapath, one per kind of work.
  typedef struct packed {
    logic load;      // latch capacity/count, clear mask and grants
    logic scanStep;  // examine one flow slot for the running minimum
    logic divStart;  // seed divider with remaining capacity
    logic divStep;   // one restoring-division quotient bit
    logic grant;     // commit grant, update capacity and count
  } mmfCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DIV,
    ST_GRANT,
    ST_DONE
  } mmfState_t;

endpackage

// File: rtl/mmf_datapath.sv
`timescale 1ns/1ps
module mmf_datapath
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 8,
  parameter int RATE_W    = 16
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  mmfCtrl_t                                     ctrl,
  input  logic [((NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1)-1:0] scanIdx,
  input  logic                                         wrEn,
  input  logic [$clog2(NUM_FLOWS+2)-1:0]               wrAddr,
  input  logic [RATE_W-1:0]                            wrData,
  input  logic [((NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1)-1:0] rdIdx,
  output logic [RATE_W-1:0]                            rdGrant,
  output logic                                         cntZero,
  output logic                                         lastRound,
  output logic [RATE_W-1:0]                            remCapOut,
  output logic [$clog2(NUM_FLOWS+1)-1:0]               remCntOut,
  output logic [RATE_W-1:0]                            grantVal
);

  localparam int IDX_W  = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;
  localparam int CNT_W  = $clog2(NUM_FLOWS + 1);
  localparam int ADDR_W = $clog2(NUM_FLOWS + 2);

  logic [RATE_W-1:0]    reqMem   [NUM_FLOWS];
  logic [RATE_W-1:0]    grantMem [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] allocMask;
  logic [RATE_W-1:0]    capReg;
  logic [CNT_W-1:0]     cntReg;
  logic [RATE_W-1:0]    remCap;
  logic [CNT_W-1:0]     remCnt;
  logic [IDX_W-1:0]     bestIdx;
  logic [RATE_W-1:0]    bestReq;
  logic                 bestValid;
  logic [CNT_W-1:0]     divRem;
  logic [RATE_W-1:0]    divQuo;

  // ---------------- configuration registers ----------------
  logic [CNT_W-1:0] cntSat;
  assign cntSat = (wrData > RATE_W'(NUM_FLOWS)) ? CNT_W'(NUM_FLOWS) : wrData[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
      cntReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(NUM_FLOWS))     capReg <= wrData;
      if (wrAddr == ADDR_W'(NUM_FLOWS + 1)) cntReg <= cntSat;
    end
  end

  // ---------------- per-flow storage ----------------
  for (genvar g = 0; g < NUM_FLOWS; g++) begin : gFlow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqMem[g] <= '0;
      end else if (wrEn && wrAddr == ADDR_W'(g)) begin
        reqMem[g] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        grantMem[g]  <= '0;
        allocMask[g] <= 1'b0;
      end else if (ctrl.load) begin
        grantMem[g]  <= '0;
        allocMask[g] <= 1'b0;
      end else if (ctrl.grant && bestIdx == IDX_W'(g)) begin
        grantMem[g]  <= grantVal;
        allocMask[g] <= 1'b1;
      end
    end
  end

  // ---------------- minimum scan ----------------
  logic [RATE_W-1:0] scanReq;
  logic              scanTakes;
  assign scanReq   = reqMem[scanIdx];
  assign scanTakes = (CNT_W'(scanIdx) < cntReg) && !allocMask[scanIdx] &&
                     (!bestValid || scanReq < bestReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestIdx   <= '0;
      bestReq   <= '0;
      bestValid <= 1'b0;
    end else if (ctrl.load || ctrl.grant) begin
      bestValid <= 1'b0;
    end else if (ctrl.scanStep && scanTakes) begin
      bestIdx   <= scanIdx;
      bestReq   <= scanReq;
      bestValid <= 1'b1;
    end
  end

  // ---------------- restoring divider: remCap / remCnt ----------------
  logic [CNT_W:0] remShift;
  logic [CNT_W:0] divisorExt;
  logic           quoBit;
  logic [CNT_W:0] remDiff;
  assign remShift   = {divRem, divQuo[RATE_W-1]};
  assign divisorExt = {1'b0, remCnt};
  assign quoBit     = (remShift >= divisorExt);
  assign remDiff    = remShift - divisorExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divRem <= '0;
      divQuo <= '0;
    end else if (ctrl.divStart) begin
      divRem <= '0;
      divQuo <= remCap;
    end else if (ctrl.divStep) begin
      divRem <= quoBit ? remDiff[CNT_W-1:0] : remShift[CNT_W-1:0];
      divQuo <= {divQuo[RATE_W-2:0], quoBit};
    end
  end

  // ---------------- grant and running totals ----------------
  assign grantVal = (bestReq <= divQuo) ? bestReq : divQuo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCap <= '0;
      remCnt <= '0;
    end else if (ctrl.load) begin
      remCap <= capReg;
      remCnt <= cntReg;
    end else if (ctrl.grant) begin
      remCap <= remCap - grantVal;
      remCnt <= remCnt - CNT_W'(1);
    end
  end

  assign cntZero   = (cntReg == '0);
  assign lastRound = (remCnt == CNT_W'(1));
  assign remCapOut = remCap;
  assign remCntOut = remCnt;
  assign rdGrant   = (32'(rdIdx) < NUM_FLOWS) ? grantMem[rdIdx] : '0;

endmodule

// File: rtl/mmf_control.sv
`timescale 1ns/1ps
module mmf_control
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 8,
  parameter int RATE_W    = 16
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         start,
  input  logic                                         cntZero,
  input  logic                                         lastRound,
  output mmfCtrl_t                                     ctrl,
  output logic [((NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1)-1:0] scanIdx,
  output logic                                         busy,
  output logic                                         done
);

  localparam int IDX_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;
  localparam int DC_W  = $clog2(RATE_W);

  mmfState_t        state, stateNxt;
  logic [DC_W-1:0]  divCnt;
  logic             scanLast;
  logic             divLast;

  assign scanLast = (scanIdx == IDX_W'(NUM_FLOWS - 1));
  assign divLast  = (divCnt == DC_W'(RATE_W - 1));

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNxt  = cntZero ? ST_DONE : ST_SCAN;
        end
      end
      ST_SCAN: begin
        ctrl.scanStep = 1'b1;
        if (scanLast) begin
          ctrl.divStart = 1'b1;
          stateNxt      = ST_DIV;
        end
      end
      ST_DIV: begin
        ctrl.divStep = 1'b1;
        if (divLast) stateNxt = ST_GRANT;
      end
      ST_GRANT: begin
        ctrl.grant = 1'b1;
        stateNxt   = lastRound ? ST_DONE : ST_SCAN;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
      divCnt  <= '0;
    end else begin
      state <= stateNxt;
      if (ctrl.load || ctrl.grant) scanIdx <= '0;
      else if (ctrl.scanStep)      scanIdx <= scanIdx + IDX_W'(1);
      if (ctrl.divStart)           divCnt <= '0;
      else if (ctrl.divStep)       divCnt <= divCnt + DC_W'(1);
    end
  end

  assign busy = (state == ST_SCAN) || (state == ST_DIV) || (state == ST_GRANT);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/mmf_alloc.sv
`timescale 1ns/1ps
module mmf_alloc
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 8,
  parameter int RATE_W    = 16
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         wrEn,
  input  logic [$clog2(NUM_FLOWS+2)-1:0]               wrAddr,
  input  logic [RATE_W-1:0]                            wrData,
  input  logic                                         start,
  output logic                                         busy,
  output logic                                         done,
  input  logic [((NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1)-1:0] rdIdx,
  output logic [RATE_W-1:0]                            rdGrant
);

  localparam int IDX_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;
  localparam int CNT_W = $clog2(NUM_FLOWS + 1);

  mmfCtrl_t          ctrl;
  logic [IDX_W-1:0]  scanIdx;
  logic              cntZero;
  logic              lastRound;
  logic [RATE_W-1:0] remCap;
  logic [CNT_W-1:0]  remCnt;
  logic [RATE_W-1:0] grantVal;
  logic              grantWe;

  assign grantWe = ctrl.grant;

  mmf_control #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cntZero   (cntZero),
    .lastRound (lastRound),
    .ctrl      (ctrl),
    .scanIdx   (scanIdx),
    .busy      (busy),
    .done      (done)
  );

  mmf_datapath #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .scanIdx   (scanIdx),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdIdx     (rdIdx),
    .rdGrant   (rdGrant),
    .cntZero   (cntZero),
    .lastRound (lastRound),
    .remCapOut (remCap),
    .remCntOut (remCnt),
    .grantVal  (grantVal)
  );

endmodule

// File: rtl/mmf_alloc_chk.sv
`timescale 1ns/1ps
module mmf_alloc_chk #(
  parameter int NUM_FLOWS = 8,
  parameter int RATE_W    = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           start,
  input logic                           busy,
  input logic                           done,
  input logic                           grantWe,
  input logic [RATE_W-1:0]              grantVal,
  input logic [RATE_W-1:0]              remCap,
  input logic [$clog2(NUM_FLOWS+1)-1:0] remCnt
);

  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_cap_not_rising_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> remCap <= $past(remCap));

  assert_no_overspend_R6: assert property (@(posedge clk) disable iff (!rstN)
    grantWe |-> grantVal <= remCap);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    grantWe |=> remCnt == $past(remCnt) - 1'b1);

endmodule

bind mmf_alloc mmf_alloc_chk #(.NUM_FLOWS(NUM_FLOWS), .RATE_W(RATE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .grantWe  (grantWe),
  .grantVal (grantVal),
  .remCap   (remCap),
  .remCnt   (remCnt)
);

// File: tb/mmf_alloc_test.sv
`timescale 1ns/1ps
module mmf_alloc_test;

  localparam int NF     = 8;
  localparam int RW     = 16;
  localparam int IDX_W  = $clog2(NF);
  localparam int ADDR_W = $clog2(NF + 2);
  localparam int ROUND  = NF + RW + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [RW-1:0]     wrData = '0;
  logic              start = 1'b0;
  logic              busy, done;
  logic [IDX_W-1:0]  rdIdx = '0;
  logic [RW-1:0]     rdGrant;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // shadow configuration and reference state
  int  shReq [NF];
  int  shCap = 0;
  int  shCnt = 0;
  int  expG  [NF];
  bit  mBusy = 1'b0;
  bit  mDone = 1'b0;
  int  cyclesLeft = 0;
  int  cycleNo = 0;

  always #2 clk = ~clk;

  mmf_alloc #(.NUM_FLOWS(NF), .RATE_W(RW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .busy(busy), .done(done), .rdIdx(rdIdx), .rdGrant(rdGrant)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Smallest-first water filling, written from the requirements.
  function automatic void computeRef();
    bit used [NF];
    int remC = shCap;
    int remN = shCnt;
    for (int i = 0; i < NF; i++) begin
      expG[i] = 0;
      used[i] = 1'b0;
    end
    while (remN > 0) begin
      int best = -1;
      int share, g;
      for (int i = 0; i < shCnt; i++)
        if (!used[i] && (best < 0 || shReq[i] < shReq[best])) best = i;
      share = remC / remN;
      g = (shReq[best] <= share) ? shReq[best] : share;
      expG[best] = g;
      used[best] = 1'b1;
      remC -= g;
      remN--;
    end
  endfunction

  // Cycle model of busy/done.
  always @(posedge clk) begin
    cycleNo++;
    if (!rstN) begin
      mBusy = 1'b0;
      mDone = 1'b0;
    end else if (!mBusy && start) begin
      computeRef();
      if (shCnt == 0) begin
        mDone = 1'b1;
      end else begin
        mBusy = 1'b1;
        mDone = 1'b0;
        cyclesLeft = shCnt * ROUND;
      end
    end else if (mBusy) begin
      cyclesLeft--;
      if (cyclesLeft == 0) begin
        mBusy = 1'b0;
        mDone = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R7 busy", int'(busy), int'(mBusy));
      check("R8 done", int'(done), int'(mDone));
    end
  end

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = ADDR_W'(addr);
    wrData = RW'(data);
    @(negedge clk);
    wrEn = 1'b0;
    if (addr < NF) shReq[addr] = data;
    else if (addr == NF) shCap = data;
    else shCnt = (data > NF) ? NF : data;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!mDone) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkGrants(input string req);
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      rdIdx = IDX_W'(i);
      #1;
      check(req, int'(rdGrant), expG[i]);
    end
  endtask

  task automatic runSet(input int cap, input int cnt, input string req);
    writeReg(NF, cap);
    writeReg(NF + 1, cnt);
    pulseStart();
    check("R2 busy after start", int'(busy), 1);
    waitDone();
    checkGrants(req);
  endtask

  initial begin
    for (int i = 0; i < NF; i++) begin
      shReq[i] = 0;
      expG[i]  = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    @(negedge clk);
    check("R2 reset busy", int'(busy), 0);
    check("R8 reset done", int'(done), 0);
    checkGrants("R11 reset grants");

    // R12 worked example (also R3, R4, R5, R6, R7)
    writeReg(0, 26); writeReg(1, 128); writeReg(2, 2560); writeReg(3, 1280);
    for (int i = 4; i < NF; i++) writeReg(i, 999);
    runSet(256, 4, "R12 model");
    rdIdx = 3'd0; #1 check("R12 flow0", int'(rdGrant), 26);
    rdIdx = 3'd1; #1 check("R12 flow1", int'(rdGrant), 76);
    rdIdx = 3'd2; #1 check("R12 flow2", int'(rdGrant), 77);
    rdIdx = 3'd3; #1 check("R12 flow3", int'(rdGrant), 77);
    rdIdx = 3'd5; #1 check("R11 outside count", int'(rdGrant), 0);

    // equal requests, tie order by index: 33, 33, 34
    writeReg(0, 40); writeReg(1, 40); writeReg(2, 40);
    runSet(100, 3, "R3 tie order");
    rdIdx = 3'd0; #1 check("R3 lowest index first", int'(rdGrant), 33);
    rdIdx = 3'd2; #1 check("R3 last served", int'(rdGrant), 34);

    // every request fits: full grants
    writeReg(0, 10); writeReg(1, 30); writeReg(2, 20);
    runSet(2000, 3, "R5 small requests");

    // request equal to share is granted in full
    writeReg(0, 100); writeReg(1, 500); writeReg(2, 100);
    runSet(300, 3, "R5 equal to share");
    rdIdx = 3'd0; #1 check("R5 equal share", int'(rdGrant), 100);

    // count above NUM_FLOWS saturates
    for (int i = 0; i < NF; i++) writeReg(i, 20 + 40 * ((i * 5) % NF));
    runSet(800, 15, "R1 saturated count");

    // share smaller than one unit (R4 floor)
    runSet(5, 8, "R4 floor share");

    // zero flows
    writeReg(NF + 1, 0);
    pulseStart();
    check("R10 done next cycle", int'(done), 1);
    checkGrants("R10 zero grants");

    // start while busy is ignored, then restart from done
    writeReg(0, 300); writeReg(1, 50); writeReg(2, 700); writeReg(3, 120); writeReg(4, 90);
    writeReg(NF, 1000);
    writeReg(NF + 1, 5);
    pulseStart();
    repeat (40) @(negedge clk);
    pulseStart();
    check("R9 still busy", int'(busy), 1);
    waitDone();
    checkGrants("R9 grants unchanged");
    runSet(600, 2, "R11 restart fewer flows");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule